// File: doc/BRIEF.md
# Decimal Digit Accumulator with Click Control

This block is a small dedicated processor that sums decimal digits. While it runs, it samples one 4-bit BCD digit on every clock and adds it to a running binary total. The total is shown as two BCD digits, tens and units. Any code above nine is treated as zero before it is added.

Two active-low pushbuttons drive a control state machine. The machine acts on a whole click, that is, a press followed by a release. A start click clears the total and begins a run. A second start click during a run clears the total and returns the machine to idle. A stop click ends the run.

A run also ends by itself when the total goes above 99. While the total is above 99, an overflow flag is raised and an active-low display-enable output is driven low, so the out-of-range value is blanked. When a run ends, a single-cycle done pulse is produced and the last total is held until the next start click.

The buttons are assumed to be clean and synchronous to the block clock. Clock division and seven-segment decoding are left to the surrounding logic.

Top module: `bcd_digit_accumulator`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block returns to idle. After that edge the total is zero, `tens_out` and `units_out` are 0, `blank_n` is 1, and `over_flag` and `done_pulse` are 0.
- R2: A digit code from 10 to 15 on `digit_in` is added as zero. Codes 0 to 9 are added at their value.
- R3: A start click begins a run. The click is `start_n` low at one or more edges, then high at an edge. The total is cleared on each edge where the button is held, and the run begins at the release edge. At each edge of the run, the digit on `digit_in` is captured, and the total adds the digit captured one edge earlier. The first add is therefore zero.
- R4: Once the total is above 99, `over_flag` is 1 and accumulation stops. The total holds its value, which is at most 108, until it is next cleared.
- R5: When a run ends, `done_pulse` is 1 for exactly one cycle. The run ends either by overflow or by a stop click. On overflow the pulse follows one cycle after `over_flag` rises.
- R6: While `over_flag` is 1, `blank_n` is 0 and both digit outputs are 0.
- R7: A stop click during a run ends it. A stop click is `stop_n` low at one or more edges, then high. The edge that first sees `stop_n` low still performs that cycle's add. No add follows. `done_pulse` is high in the cycle after the release edge.
- R8: A start press during a run ends the run without any done pulse. Start has priority over stop and overflow. The total is cleared, and the machine waits in idle after the release.
- R9: While idle, `digit_in` and `stop_n` have no effect. The last total stays on the outputs until a start click.
- R10: While the total is 99 or less, `tens_out` and `units_out` are its decimal tens and units digits.
- R11: Holding a button down for any number of cycles produces one action only. Holding start does not begin accumulation before the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_n | input | 1 | Start pushbutton, active low |
| stop_n | input | 1 | Stop pushbutton, active low |
| digit_in | input | 4 | BCD digit sampled during a run |
| tens_out | output | 4 | Tens digit of the total |
| units_out | output | 4 | Units digit of the total |
| blank_n | output | 1 | Display enable, low while the total is above 99 |
| over_flag | output | 1 | Total is greater than 99 |
| done_pulse | output | 1 | One-cycle end-of-run strobe |

## Verification
A wrong control state shows up at the digit outputs within one or two cycles. A missing clear shows as a stale total after a start click. An extra or missed add shows as a units digit that is off by the captured digit on the next cycle. A run state that does not end shows as a total that keeps growing after overflow, or a done strobe that does not come.

Errors in the display converter or the overflow compare show up at once. Both are combinational from the total register, so a wrong tens or units digit, or a wrong blank level, appears in the same cycle as the total that causes it.

// File: rtl/bcd_acc_pkg.sv
package bcd_acc_pkg;

  localparam int unsigned DIG_W     = 4;
  localparam int unsigned ACC_W     = 7;
  localparam int unsigned MAX_DIGIT = 9;
  localparam int unsigned LIMIT     = 99;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_RUN,
    ST_RST_HOLD,
    ST_STOP_HOLD,
    ST_DONE
  } ctrl_state_t;

  // Codes outside the decimal range contribute nothing.
  function automatic logic [DIG_W-1:0] sanitize_digit(input logic [DIG_W-1:0] d);
    return (d > DIG_W'(MAX_DIGIT)) ? '0 : d;
  endfunction

  // Shift-and-add-three conversion. The result holds tens in [7:4] and units in [3:0].
  function automatic logic [7:0] bin_to_bcd2(input logic [ACC_W-1:0] v);
    logic [11:0] sc;
    sc = '0;
    for (int i = ACC_W - 1; i >= 0; i--) begin
      if (sc[3:0]  >= 4'd5) sc[3:0]  = sc[3:0]  + 4'd3;
      if (sc[7:4]  >= 4'd5) sc[7:4]  = sc[7:4]  + 4'd3;
      if (sc[11:8] >= 4'd5) sc[11:8] = sc[11:8] + 4'd3;
      sc = {sc[10:0], v[i]};
    end
    return sc[7:0];
  endfunction

endpackage

// File: rtl/bcd_acc_ctrl.sv
module bcd_acc_ctrl
  import bcd_acc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_n,
  input  logic stop_n,
  input  logic end_flag,
  output logic clr,
  output logic cap_en,
  output logic acc_en,
  output logic done
);

  ctrl_state_t state_q, state_d;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (!start_n) state_d = ST_ARM;
      ST_ARM:       if (start_n)  state_d = ST_RUN;
      ST_RUN: begin
        if (!start_n)     state_d = ST_RST_HOLD;
        else if (!stop_n) state_d = ST_STOP_HOLD;
        else if (end_flag) state_d = ST_DONE;
      end
      ST_RST_HOLD:  if (start_n)  state_d = ST_IDLE;
      ST_STOP_HOLD: if (stop_n)   state_d = ST_DONE;
      ST_DONE:      state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  assign clr    = (state_q == ST_ARM) || (state_q == ST_RST_HOLD);
  assign cap_en = (state_q == ST_RUN);
  assign acc_en = (state_q == ST_RUN) && !end_flag;
  assign done   = (state_q == ST_DONE);

endmodule

// File: rtl/bcd_acc_datapath.sv
module bcd_acc_datapath
  import bcd_acc_pkg::*;
#(
  parameter int unsigned DW  = DIG_W,
  parameter int unsigned AW  = ACC_W,
  parameter int unsigned LIM = LIMIT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cap_en,
  input  logic          acc_en,
  input  logic [DW-1:0] digit_raw,
  output logic [DW-1:0] dig_q,
  output logic [AW-1:0] acc_q,
  output logic          gt
);

  localparam int unsigned PEAK = LIM + MAX_DIGIT;
  localparam logic [AW-1:0] LIM_V = AW'(LIM);

  logic [DW-1:0] dig_clean;
  logic [AW-1:0] acc_sum;

  assign dig_clean = sanitize_digit(digit_raw);
  assign acc_sum   = acc_q + AW'(dig_q);
  assign gt        = acc_q > LIM_V;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)  dig_q <= '0;
    else if (cap_en)    dig_q <= dig_clean;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr)  acc_q <= '0;
    else if (acc_en)    acc_q <= acc_sum;
  end

  initial begin
    if (PEAK >= (1 << AW)) $display("bcd_acc_datapath: total width too small for %0d", PEAK);
  end

endmodule

// File: rtl/bcd_acc_display.sv
module bcd_acc_display
  import bcd_acc_pkg::*;
#(
  parameter int unsigned AW = ACC_W
) (
  input  logic [AW-1:0] acc_q,
  input  logic          gt,
  output logic [3:0]    tens,
  output logic [3:0]    units,
  output logic          blank_n
);

  logic [7:0] bcd;

  assign bcd     = bin_to_bcd2(acc_q);
  assign tens    = gt ? 4'd0 : bcd[7:4];
  assign units   = gt ? 4'd0 : bcd[3:0];
  assign blank_n = ~gt;

endmodule

// File: rtl/bcd_digit_accumulator.sv
module bcd_digit_accumulator
  import bcd_acc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_n,
  input  logic             stop_n,
  input  logic [DIG_W-1:0] digit_in,
  output logic [3:0]       tens_out,
  output logic [3:0]       units_out,
  output logic             blank_n,
  output logic             over_flag,
  output logic             done_pulse
);

  logic             clr;
  logic             cap_en;
  logic             acc_en;
  logic             gt;
  logic [DIG_W-1:0] dig_q;
  logic [ACC_W-1:0] acc_q;

  bcd_acc_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_n  (start_n),
    .stop_n   (stop_n),
    .end_flag (gt),
    .clr      (clr),
    .cap_en   (cap_en),
    .acc_en   (acc_en),
    .done     (done_pulse)
  );

  bcd_acc_datapath #(.DW(DIG_W), .AW(ACC_W), .LIM(LIMIT)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .cap_en    (cap_en),
    .acc_en    (acc_en),
    .digit_raw (digit_in),
    .dig_q     (dig_q),
    .acc_q     (acc_q),
    .gt        (gt)
  );

  bcd_acc_display #(.AW(ACC_W)) u_disp (
    .acc_q   (acc_q),
    .gt      (gt),
    .tens    (tens_out),
    .units   (units_out),
    .blank_n (blank_n)
  );

  assign over_flag = gt;

endmodule

// File: rtl/bcd_acc_checker.sv
module bcd_acc_checker
  import bcd_acc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             acc_en,
  input logic [DIG_W-1:0] dig_q,
  input logic [ACC_W-1:0] acc_q,
  input logic [3:0]       tens_out,
  input logic [3:0]       units_out,
  input logic             blank_n,
  input logic             over_flag,
  input logic             done_pulse
);

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (acc_q == '0 && !done_pulse));

  a_r2_digit_valid: assert property (@(posedge clk) disable iff (!rst_n)
    dig_q <= DIG_W'(MAX_DIGIT));

  a_r3_accum_step: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |=> acc_q == ACC_W'($past(acc_q) + ACC_W'($past(dig_q))));

  a_r4_hold_over: assert property (@(posedge clk) disable iff (!rst_n)
    (over_flag && !clr) |=> $stable(acc_q));

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  a_r6_blank_on_over: assert property (@(posedge clk) disable iff (!rst_n)
    over_flag |-> (!blank_n && tens_out == 4'd0 && units_out == 4'd0));

  a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0 && dig_q == '0));

  a_r10_digits_decimal: assert property (@(posedge clk) disable iff (!rst_n)
    (tens_out <= 4'd9 && units_out <= 4'd9));

endmodule

bind bcd_digit_accumulator bcd_acc_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr        (clr),
  .acc_en     (acc_en),
  .dig_q      (dig_q),
  .acc_q      (acc_q),
  .tens_out   (tens_out),
  .units_out  (units_out),
  .blank_n    (blank_n),
  .over_flag  (over_flag),
  .done_pulse (done_pulse)
);

// File: tb/bcd_digit_accumulator_test.sv
module bcd_digit_accumulator_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_n = 1'b1;
  logic       stop_n = 1'b1;
  logic [3:0] digit_in = 4'd0;
  logic [3:0] tens_out, units_out;
  logic       blank_n, over_flag, done_pulse;

  int n_chk = 0;
  int n_bad = 0;
  int done_cnt = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bcd_digit_accumulator uut (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .stop_n(stop_n),
    .digit_in(digit_in), .tens_out(tens_out), .units_out(units_out),
    .blank_n(blank_n), .over_flag(over_flag), .done_pulse(done_pulse)
  );

  // Reference model states
  localparam int M_IDLE = 0, M_ARM = 1, M_RUN = 2, M_RH = 3, M_SH = 4, M_DN = 5;
  int m_st = M_IDLE;
  int m_dig = 0;
  int m_tot = 0;

  function automatic int clean(input int d);
    return (d >= 10) ? 0 : d;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st <= M_IDLE; m_dig <= 0; m_tot <= 0;
    end else begin
      case (m_st)
        M_IDLE: if (!start_n) m_st <= M_ARM;
        M_ARM: begin m_dig <= 0; m_tot <= 0; if (start_n) m_st <= M_RUN; end
        M_RUN: begin
          m_dig <= clean(int'(digit_in));
          if (m_tot <= 99) m_tot <= m_tot + m_dig;
          if (!start_n) m_st <= M_RH;
          else if (!stop_n) m_st <= M_SH;
          else if (m_tot > 99) m_st <= M_DN;
        end
        M_RH: begin m_dig <= 0; m_tot <= 0; if (start_n) m_st <= M_IDLE; end
        M_SH: if (stop_n) m_st <= M_DN;
        default: m_st <= M_IDLE;
      endcase
      if (done_pulse) done_cnt <= done_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      automatic bit ov = m_tot > 99;
      automatic int et = ov ? 0 : m_tot / 10;
      automatic int eu = ov ? 0 : m_tot % 10;
      check(int'(tens_out) == et,  "R10 tens", int'(tens_out), et);
      check(int'(units_out) == eu, "R10 units", int'(units_out), eu);
      check(over_flag == ov,       "R4 over", int'(over_flag), int'(ov));
      check(blank_n == !ov,        "R6 blank", int'(blank_n), int'(!ov));
      check(done_pulse == (m_st == M_DN), "R5 done", int'(done_pulse), int'(m_st == M_DN));
    end
  end

  task automatic step(input bit s, input bit p, input int d);
    start_n = s; stop_n = p; digit_in = 4'(d);
    @(negedge clk);
  endtask

  task automatic click_start(input int hold);
    for (int i = 0; i < hold; i++) step(1'b0, 1'b1, 9);
    step(1'b1, 1'b1, 0);
  endtask

  function automatic int shown();
    return int'(tens_out) * 10 + int'(units_out);
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int dc0;
    void'($urandom(32'd20240611));
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(shown() == 0 && blank_n && !over_flag && !done_pulse, "R1 reset outputs", shown(), 0);

    // R9 idle ignores digits and stop
    step(1, 0, 7); step(1, 1, 5); step(1, 0, 3);
    check(shown() == 0, "R9 idle ignores inputs", shown(), 0);

    // R11 long start hold with digit 9 does not accumulate
    for (int i = 0; i < 10; i++) step(0, 1, 9);
    check(shown() == 0, "R11 held start no add", shown(), 0);
    step(1, 1, 0);
    // R2 invalid codes count as zero
    step(1, 1, 12); step(1, 1, 5); step(1, 1, 15); step(1, 1, 3); step(1, 1, 0);
    check(shown() == 8, "R2 invalid zeroed", shown(), 8);
    // R3 one-cycle lag: digit 4 captured but not yet added
    step(1, 1, 4);
    check(shown() == 8, "R3 lag one cycle", shown(), 8);
    // R7 stop click: this edge still adds the captured 4
    dc0 = done_cnt;
    step(1, 0, 7);
    check(shown() == 12, "R7 last add on stop edge", shown(), 12);
    step(1, 0, 7);
    check(!done_pulse, "R7 no done while held", int'(done_pulse), 0);
    step(1, 1, 0);
    check(done_pulse, "R7 done after release", int'(done_pulse), 1);
    step(1, 1, 9);
    check(!done_pulse && done_cnt == dc0 + 1, "R5 single pulse", done_cnt - dc0, 1);
    step(1, 1, 9); step(1, 0, 9); step(1, 1, 9);
    check(shown() == 12, "R9 total held after done", shown(), 12);

    // R8 restart during run
    click_start(2);
    check(shown() == 0, "R3 start clears", shown(), 0);
    dc0 = done_cnt;
    step(1, 1, 4); step(1, 1, 4); step(0, 1, 0);
    check(shown() == 8, "R8 add on press edge", shown(), 8);
    step(0, 1, 6); step(1, 1, 6);
    for (int i = 0; i < 4; i++) step(1, 1, 6);
    check(shown() == 0 && done_cnt == dc0, "R8 cleared no done", shown(), 0);

    // R4 overflow with digit 9
    click_start(1);
    dc0 = done_cnt;
    for (int i = 0; i < 16; i++) step(1, 1, 9);
    check(over_flag && !blank_n, "R4 overflow flag", int'(over_flag), 1);
    check(shown() == 0, "R6 digits zero on over", shown(), 0);
    check(done_cnt == dc0 + 1, "R5 done on overflow", done_cnt - dc0, 1);
    for (int i = 0; i < 5; i++) step(1, 1, 9);
    check(over_flag, "R4 over held idle", int'(over_flag), 1);

    // R10 exact 99 is not over
    click_start(1);
    for (int i = 0; i < 11; i++) step(1, 1, 9);
    step(1, 0, 0);
    step(1, 1, 0); step(1, 1, 0);
    check(shown() == 99 && !over_flag, "R10 ninety-nine shown", shown(), 99);

    // Random traffic checked by the model
    for (int i = 0; i < 1500; i++) begin
      automatic int r = int'($urandom % 60);
      if (r == 0) begin
        for (int k = 0; k <= int'($urandom % 3); k++) step(0, 1, int'($urandom % 16));
      end else if (r == 1) begin
        for (int k = 0; k <= int'($urandom % 3); k++) step(1, 0, int'($urandom % 16));
      end else begin
        step(1, 1, int'($urandom % 16));
      end
    end

    // R1 reset mid-run
    click_start(1);
    step(1, 1, 7); step(1, 1, 7);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(shown() == 0 && !done_pulse, "R1 reset in run", shown(), 0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule